// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-facing register file of a four-channel DMA controller that sits on an 8-bit I/O bus. Each channel has a 16-bit start address and a 16-bit transfer count. Both have a base copy that software writes and a current copy that the transfer engine advances. An 8-bit bus cannot move 16 bits in one access, so each of these registers is reached through one byte-wide port. A single pointer flip-flop, shared by all eight ports, decides whether an access touches the low byte or the high byte.

Channel selection, mode fields and mask bits are packed into write-only command bytes. The register file decodes these bytes and presents the resulting per-channel configuration to a separate transfer engine. It also:
- gates request lines with the mask bits and a global disable bit,
- collects terminal-count events into a status byte that clears when read,
- reloads current registers from their base copies when a channel set for auto-initialisation reaches terminal count.

Software programs a count as the number of transfers minus one.

Top module: `dma_regfile`

## Requirements
- R1: Any write to port 12 sets the byte pointer to low. Each read or write on ports 0..7 uses the low byte when the pointer is low and the high byte when it is high, and toggles the pointer afterwards.
- R2: Port 2n is channel n's address and port 2n+1 is its count. A byte write loads that byte of both the base and the current register. Reads return the matching byte of the current register.
- R3: A write to port 13 (master reset) sets the pointer low and clears the terminal-count status bits and all software requests. It also sets all four mask bits.
- R4: A write to port 10 (single mask) uses wdata[1:0] as the channel and writes wdata[2] into that channel's mask bit (1 = masked).
- R5: A write to port 14 clears all mask bits. A write to port 15 loads mask bit n from wdata[n].
- R6: A write to port 11 (mode) uses wdata[1:0] as the channel and stores wdata[7:2] into that channel's 6-bit slice of cfg_mode, at cfg_mode[6n+5:6n]. Within the slice:
  - bits [1:0] are the transfer type (00 verify, 01 write to memory, 10 read from memory),
  - bit 2 is auto-init,
  - bit 3 is address decrement,
  - bits [5:4] are the mode (0 demand, 1 single, 2 block, 3 cascade).
- R7: Status (a read of port 8) returns terminal-count flags in bits [3:0] and pending requests in bits [7:4].
  - A tc_pulse bit sets its flag, and the flag holds until a status read or a master reset clears it.
  - A tc_pulse that arrives in the same cycle as the clear still leaves its flag set.
- R8: Command port 8 is write-only. Bit 2 drives ctrl_disable, which forces ch_req to zero. The other command bits have no effect.
- R9: A write to port 9 (request) uses wdata[1:0] as the channel and sets (wdata[2]=1) or clears (wdata[2]=0) that channel's software request.
- R10: When the controller is enabled, ch_req[n] = (dreq[n] or software request n) and not mask[n]. Status bits [7:4] show (dreq or software request), without masking.
- R11: When upd_valid is high, the current address and count of upd_ch are loaded from upd_addr and upd_cnt.
  - A tc_pulse on a channel whose auto-init bit is set instead copies that channel's base registers into its current registers.
  - A processor byte write in the same cycle takes precedence, for its byte only.
- R12: After reset:
  - all masks are set and the pointer is low,
  - the command, mode, status, request, base and current registers are zero,
  - reads of ports 9..15 always return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Port select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access (ignored while wr_en is high) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port, combinational |
| dreq | input | 4 | Live hardware request per channel |
| tc_pulse | input | 4 | Terminal-count event per channel from the engine |
| upd_valid | input | 1 | Engine update strobe |
| upd_ch | input | 2 | Channel written by the engine update |
| upd_addr | input | 16 | New current address from the engine |
| upd_cnt | input | 16 | New current count from the engine |
| ch_mask | output | 4 | Mask bit per channel |
| ch_req | output | 4 | Gated request per channel |
| ctrl_disable | output | 1 | Controller disabled by command bit 2 |
| cfg_mode | output | 24 | Six mode bits per channel |
| cur_addr | output | 64 | Current address, 16 bits per channel |
| cur_cnt | output | 64 | Current count, 16 bits per channel |

## Verification
The bench builds the block with its defaults: four channels and 8-bit bytes. With these values the 4-bit port map is fully populated, both pointer states are reached on every 16-bit register, and the two channel-select bits in the command bytes address every channel. A behavioural model runs next to the design and is compared on every clock. Directed sequences cover these cases:
- a pointer left high before a clear,
- a status read that coincides with a new terminal count,
- an engine update that collides with an auto-init reload,
- software requests that are hidden by masking and by the global disable.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int BW  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                addr,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [BW-1:0]             wdata,
  output logic [BW-1:0]             rdata,
  input  logic [NCH-1:0]            dreq,
  input  logic [NCH-1:0]            tc_pulse,
  input  logic                      upd_valid,
  input  logic [$clog2(NCH)-1:0]    upd_ch,
  input  logic [2*BW-1:0]           upd_addr,
  input  logic [2*BW-1:0]           upd_cnt,
  output logic [NCH-1:0]            ch_mask,
  output logic [NCH-1:0]            ch_req,
  output logic                      ctrl_disable,
  output logic [6*NCH-1:0]          cfg_mode,
  output logic [2*BW*NCH-1:0]       cur_addr,
  output logic [2*BW*NCH-1:0]       cur_cnt
);
  localparam int RW  = 2 * BW;
  localparam int CHW = $clog2(NCH);
  localparam int MW  = BW - 2;

  localparam logic [3:0] P_CMD   = 4'd8;
  localparam logic [3:0] P_REQ   = 4'd9;
  localparam logic [3:0] P_SMASK = 4'd10;
  localparam logic [3:0] P_MODE  = 4'd11;
  localparam logic [3:0] P_FFCLR = 4'd12;
  localparam logic [3:0] P_MRST  = 4'd13;
  localparam logic [3:0] P_MCLR  = 4'd14;
  localparam logic [3:0] P_MMASK = 4'd15;

  logic           ptr;
  logic [RW-1:0]  base_a [NCH];
  logic [RW-1:0]  base_c [NCH];
  logic [RW-1:0]  cur_a  [NCH];
  logic [RW-1:0]  cur_c  [NCH];
  logic [MW-1:0]  mode_r [NCH];
  logic [BW-1:0]  cmd_r;
  logic [NCH-1:0] tc_r;
  logic [NCH-1:0] sreq_r;
  logic [NCH-1:0] mask_r;

  logic           rd_q;
  logic           pair_sel;
  logic [CHW-1:0] pch;
  logic [CHW-1:0] wch;
  logic           tc_clr;
  logic [RW-1:0]  word_sel;

  assign rd_q     = rd_en & ~wr_en;
  assign pair_sel = ~addr[3];
  assign pch      = addr[CHW:1];
  assign wch      = wdata[CHW-1:0];
  assign tc_clr   = (rd_q && addr == P_CMD) || (wr_en && addr == P_MRST);

  assign ctrl_disable = cmd_r[2];
  assign ch_mask      = mask_r;
  assign ch_req       = ctrl_disable ? '0 : ((dreq | sreq_r) & ~mask_r);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_out
      assign cfg_mode[g*MW +: MW] = mode_r[g];
      assign cur_addr[g*RW +: RW] = cur_a[g];
      assign cur_cnt[g*RW +: RW]  = cur_c[g];
    end
  endgenerate

  assign word_sel = addr[0] ? cur_c[pch] : cur_a[pch];

  always_comb begin
    rdata = '0;
    if (pair_sel)
      rdata = ptr ? word_sel[RW-1:BW] : word_sel[BW-1:0];
    else if (addr == P_CMD)
      rdata = {dreq | sreq_r, tc_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= 1'b0;
      cmd_r  <= '0;
      tc_r   <= '0;
      sreq_r <= '0;
      mask_r <= '1;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        mode_r[i] <= '0;
      end
    end else begin
      tc_r <= (tc_clr ? '0 : tc_r) | tc_pulse;

      if (upd_valid) begin
        cur_a[upd_ch] <= upd_addr;
        cur_c[upd_ch] <= upd_cnt;
      end

      for (int i = 0; i < NCH; i++) begin
        if (tc_pulse[i] && mode_r[i][2]) begin
          cur_a[i] <= base_a[i];
          cur_c[i] <= base_c[i];
        end
      end

      if (wr_en) begin
        if (pair_sel) begin
          if (addr[0]) begin
            if (ptr) begin
              base_c[pch][RW-1:BW] <= wdata;
              cur_c[pch][RW-1:BW]  <= wdata;
            end else begin
              base_c[pch][BW-1:0]  <= wdata;
              cur_c[pch][BW-1:0]   <= wdata;
            end
          end else begin
            if (ptr) begin
              base_a[pch][RW-1:BW] <= wdata;
              cur_a[pch][RW-1:BW]  <= wdata;
            end else begin
              base_a[pch][BW-1:0]  <= wdata;
              cur_a[pch][BW-1:0]   <= wdata;
            end
          end
        end else begin
          case (addr)
            P_CMD:   cmd_r <= wdata;
            P_REQ:   sreq_r[wch] <= wdata[2];
            P_SMASK: mask_r[wch] <= wdata[2];
            P_MODE:  mode_r[wch] <= wdata[BW-1:2];
            P_MRST: begin
              mask_r <= '1;
              sreq_r <= '0;
            end
            P_MCLR:  mask_r <= '0;
            P_MMASK: mask_r <= wdata[NCH-1:0];
            default: ;
          endcase
        end
      end

      if ((wr_en || rd_en) && pair_sel)
        ptr <= ~ptr;
      else if (wr_en && (addr == P_FFCLR || addr == P_MRST))
        ptr <= 1'b0;
    end
  end
endmodule

module dma_regfile_chk #(
  parameter int NCH = 4,
  parameter int BW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [BW-1:0]    wdata,
  input logic [NCH-1:0]   tc_pulse,
  input logic [NCH-1:0]   ch_mask,
  input logic [NCH-1:0]   ch_req,
  input logic             ctrl_disable,
  input logic             ptr,
  input logic [NCH-1:0]   tc_r
);
  // R1
  ffclr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd12) |=> !ptr);
  // R1
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !addr[3]) |=> (ptr != $past(ptr)));
  // R3
  master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd13) |=> (ch_mask == '1 && !ptr));
  // R4
  single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd10) |=> (ch_mask[$past(wdata[1:0])] == $past(wdata[2])));
  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd14) |=> (ch_mask == '0));
  // R5
  multi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd15) |=> (ch_mask == $past(wdata[NCH-1:0])));
  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 4'd8) |=> (tc_r == $past(tc_pulse)));
  // R7
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse != '0) |=> ((tc_r & $past(tc_pulse)) == $past(tc_pulse)));
  // R8
  disable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_disable |-> (ch_req == '0));
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .tc_pulse(tc_pulse), .ch_mask(ch_mask), .ch_req(ch_req),
  .ctrl_disable(ctrl_disable), .ptr(ptr), .tc_r(tc_r)
);

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  tc_pulse = '0;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_ch = '0;
  logic [15:0] upd_addr = '0;
  logic [15:0] upd_cnt = '0;
  logic [3:0]  ch_mask;
  logic [3:0]  ch_req;
  logic        ctrl_disable;
  logic [23:0] cfg_mode;
  logic [63:0] cur_addr;
  logic [63:0] cur_cnt;

  dma_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .dreq(dreq), .tc_pulse(tc_pulse),
    .upd_valid(upd_valid), .upd_ch(upd_ch), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
    .ch_mask(ch_mask), .ch_req(ch_req), .ctrl_disable(ctrl_disable),
    .cfg_mode(cfg_mode), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ba [4];
  logic [15:0] m_bc [4];
  logic [15:0] m_ca [4];
  logic [15:0] m_cc [4];
  logic [5:0]  m_mode [4];
  logic [7:0]  m_cmd;
  logic [3:0]  m_tc, m_sreq, m_mask;
  bit          m_ptr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_cmd = 0; m_tc = 0; m_sreq = 0; m_mask = 4'hF; m_ptr = 0;
    end else begin
      int a;
      int c;
      a = int'(addr);
      c = int'(wdata[1:0]);
      if ((rd_en && !wr_en && a == 8) || (wr_en && a == 13)) m_tc = 0;
      m_tc = m_tc | tc_pulse;
      if (upd_valid) begin
        m_ca[upd_ch] = upd_addr;
        m_cc[upd_ch] = upd_cnt;
      end
      for (int i = 0; i < 4; i++)
        if (tc_pulse[i] && m_mode[i][2]) begin
          m_ca[i] = m_ba[i];
          m_cc[i] = m_bc[i];
        end
      if (wr_en) begin
        if (a < 8) begin
          int n;
          n = a / 2;
          if (a % 2 == 1) begin
            if (m_ptr) begin m_bc[n][15:8] = wdata; m_cc[n][15:8] = wdata; end
            else begin m_bc[n][7:0] = wdata; m_cc[n][7:0] = wdata; end
          end else begin
            if (m_ptr) begin m_ba[n][15:8] = wdata; m_ca[n][15:8] = wdata; end
            else begin m_ba[n][7:0] = wdata; m_ca[n][7:0] = wdata; end
          end
        end else if (a == 8) m_cmd = wdata;
        else if (a == 9) m_sreq[c] = wdata[2];
        else if (a == 10) m_mask[c] = wdata[2];
        else if (a == 11) m_mode[c] = wdata[7:2];
        else if (a == 13) begin m_mask = 4'hF; m_sreq = 0; end
        else if (a == 14) m_mask = 0;
        else if (a == 15) m_mask = wdata[3:0];
      end
      if ((wr_en || rd_en) && a < 8) m_ptr = !m_ptr;
      else if (wr_en && (a == 12 || a == 13)) m_ptr = 0;
    end
  end

  function automatic logic [7:0] exp_rdata();
    int a;
    logic [15:0] w;
    a = int'(addr);
    if (a < 8) begin
      w = (a % 2 == 1) ? m_cc[a/2] : m_ca[a/2];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 8) return {dreq | m_sreq, m_tc};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (running && !done) begin
      logic [23:0] e_mode;
      logic [63:0] e_a, e_c;
      for (int i = 0; i < 4; i++) begin
        e_mode[i*6 +: 6] = m_mode[i];
        e_a[i*16 +: 16] = m_ca[i];
        e_c[i*16 +: 16] = m_cc[i];
      end
      chk("R5 ch_mask model", 64'(ch_mask), 64'(m_mask));
      chk("R10 ch_req model", 64'(ch_req), m_cmd[2] ? 64'd0 : 64'((dreq | m_sreq) & ~m_mask));
      chk("R8 ctrl_disable model", 64'(ctrl_disable), 64'(m_cmd[2]));
      chk("R6 cfg_mode model", 64'(cfg_mode), 64'(e_mode));
      chk("R11 cur_addr model", cur_addr, e_a);
      chk("R11 cur_cnt model", cur_cnt, e_c);
      chk("R2 rdata model", 64'(rdata), 64'(exp_rdata()));
    end
  end

  // each operation starts just after a rising edge and lasts one cycle
  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; tc_pulse = 0; upd_valid = 0;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    step();
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd_en = 1;
    @(negedge clk); v = rdata;
    step();
  endtask

  task automatic idle();
    step();
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;
    idle();

    // R12 reset state
    chk("R12 mask after reset", 64'(ch_mask), 64'hF);
    chk("R12 cur_addr after reset", cur_addr, 64'd0);
    do_rd(4'd8, v); chk("R12 status after reset", 64'(v), 64'h00);
    do_wr(4'd9, 8'h07);
    do_rd(4'd9, v); chk("R12 write-only port reads zero", 64'(v), 64'h00);
    do_wr(4'd9, 8'h03);

    // R1 / R2 byte sequencing
    do_wr(4'd12, 8'h00);
    do_wr(4'd2, 8'h34); do_wr(4'd2, 8'h12);
    do_wr(4'd3, 8'hFF); do_wr(4'd3, 8'h01);
    chk("R2 ch1 address", 64'(cur_addr[31:16]), 64'h1234);
    chk("R2 ch1 count", 64'(cur_cnt[31:16]), 64'h01FF);
    do_wr(4'd12, 8'h5A);
    do_rd(4'd2, v); chk("R2 addr low read", 64'(v), 64'h34);
    do_rd(4'd2, v); chk("R2 addr high read", 64'(v), 64'h12);
    do_rd(4'd3, v); chk("R2 count low read", 64'(v), 64'hFF);
    do_rd(4'd3, v); chk("R2 count high read", 64'(v), 64'h01);
    do_wr(4'd4, 8'hAA);
    do_wr(4'd12, 8'h00);
    do_wr(4'd4, 8'hBB); do_wr(4'd4, 8'hCC);
    chk("R1 clear restarts at low byte", 64'(cur_addr[47:32]), 64'hCCBB);
    do_wr(4'd5, 8'h10); do_wr(4'd5, 8'h00);

    // R6 mode: ch2, block, decrement, auto-init, write-to-memory
    do_wr(4'd11, 8'hB6);
    chk("R6 ch2 mode slice", 64'(cfg_mode[17:12]), 64'h2D);

    // R4 single mask
    do_wr(4'd10, 8'h02);
    chk("R4 unmask ch2", 64'(ch_mask), 64'hB);
    do_wr(4'd10, 8'h06);
    chk("R4 mask ch2", 64'(ch_mask), 64'hF);
    do_wr(4'd10, 8'h02);

    // R10 request gating
    dreq = 4'b0110;
    idle();
    chk("R10 masked request gating", 64'(ch_req), 64'b0100);

    // R8 command disable
    do_wr(4'd8, 8'h04);
    chk("R8 disable flag", 64'(ctrl_disable), 64'd1);
    chk("R8 disabled request", 64'(ch_req), 64'd0);
    do_wr(4'd8, 8'hFB);
    chk("R8 other bits ignored", 64'(ch_req), 64'b0100);

    // R9 software request
    do_wr(4'd9, 8'h07);
    do_rd(4'd8, v); chk("R9 soft request in status", 64'(v[7:4]), 64'b1110);
    do_wr(4'd10, 8'h03);
    chk("R9 soft request to ch_req", 64'(ch_req), 64'b1100);
    do_wr(4'd9, 8'h03);
    chk("R9 soft request cleared", 64'(ch_req), 64'b0100);

    // R7 terminal count status
    tc_pulse = 4'b0001; idle();
    do_rd(4'd8, v); chk("R7 tc flag read", 64'(v[3:0]), 64'b0001);
    do_rd(4'd8, v); chk("R7 tc cleared by read", 64'(v[3:0]), 64'b0000);
    tc_pulse = 4'b1000;
    do_rd(4'd8, v); chk("R7 read beside new tc", 64'(v[3:0]), 64'b0000);
    do_rd(4'd8, v); chk("R7 coincident tc kept", 64'(v[3:0]), 64'b1000);

    // R11 engine update and auto-init reload
    upd_valid = 1; upd_ch = 2'd2; upd_addr = 16'h1111; upd_cnt = 16'h0005;
    idle();
    chk("R11 engine address", 64'(cur_addr[47:32]), 64'h1111);
    chk("R11 engine count", 64'(cur_cnt[47:32]), 64'h0005);
    tc_pulse = 4'b0100; upd_valid = 1; upd_addr = 16'h2222;
    idle();
    chk("R11 auto-init address reload", 64'(cur_addr[47:32]), 64'hCCBB);
    chk("R11 auto-init count reload", 64'(cur_cnt[47:32]), 64'h0010);
    tc_pulse = 4'b0010; idle();
    chk("R11 no reload without auto-init", 64'(cur_addr[31:16]), 64'h1234);

    // R5 mask group writes
    do_wr(4'd15, 8'hFA);
    chk("R5 multi mask", 64'(ch_mask), 64'hA);
    do_wr(4'd14, 8'h00);
    chk("R5 mask reset", 64'(ch_mask), 64'h0);

    // R3 master reset
    do_wr(4'd9, 8'h05);
    tc_pulse = 4'b0010; idle();
    do_wr(4'd6, 8'h77);
    do_wr(4'd13, 8'h00);
    chk("R3 masks set", 64'(ch_mask), 64'hF);
    do_rd(4'd8, v); chk("R3 status cleared", 64'(v), 64'({4'b0110, 4'b0000}));
    do_wr(4'd6, 8'h99);
    chk("R3 pointer low after reset", 64'(cur_addr[63:48]), 64'h0099);
    do_wr(4'd14, 8'h00);
    chk("R3 soft requests cleared", 64'(ch_req), 64'b0110);

    dreq = 0;
    idle(); idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule